// File: doc/BRIEF.md
# Sync and Shutdown Pin Discriminator

This block watches a single dual-purpose control pin that arrives as a digital level, asynchronous to the system clock. The block classifies each high interval on that pin by how long it lasts.

A high interval that lasts a short but qualifying time is a synchronization event. The block marks it with a one-cycle strobe. The switching oscillator uses that strobe to restart its period. A high interval that lasts long enough is a shutdown request. The block then raises a shutdown level and forces every gate-drive enable low.

When the pin drops after a shutdown, the block releases the shutdown. In that same cycle it issues a one-cycle soft-start request, so that the converter resumes only through a full soft-start.

Pulse widths are counted in system-clock ticks after a two-flop synchronizer. The qualification and shutdown thresholds are parameters. The defaults assume a 50 MHz clock: 5 ticks is 100 ns, and 1100 ticks is 22 µs. The shutdown threshold must lie between the longest sync pulse (10 µs) and the guaranteed shutdown hold (35 µs).

Top module: `sdsync_discriminator`

## Requirements
- R1: After reset the block is in the run state: `shutdown`, `sync_pulse` and `soft_start` are 0, and `drv_en` equals `drv_req`.
- R2: A high interval of fewer than SYNC_TICKS clock samples produces no sync strobe and no other output change.
- R3: A high interval of at least SYNC_TICKS samples produces a one-cycle `sync_pulse`. If the pin is first sampled high at clock edge N, the strobe is visible in the cycle after edge N+SYNC_TICKS+1. The latency covers two synchronizer stages and the qualification count.
- R4: Only one strobe is issued per high interval, however long the pin stays high. A new strobe needs the pin to go low first.
- R5: A high interval of HALT_TICKS-1 samples or fewer never asserts `shutdown`.
- R6: A high interval of HALT_TICKS samples or more asserts `shutdown`. If the pin is first sampled high at edge N, the level is visible after edge N+HALT_TICKS+1, and it holds while the pin stays high.
- R7: While `shutdown` is 1, every bit of `drv_en` is 0 whatever `drv_req` is. Otherwise `drv_en` equals `drv_req` in the same cycle.
- R8: When the pin falls while in shutdown, `shutdown` clears and `soft_start` is 1 for exactly one cycle. Both changes are visible after the third clock edge following the fall.
- R9: Sync strobes need no minimum spacing. Qualifying pulses separated by a single low sample each produce their own strobe.
- R10: A high interval that ends without reaching shutdown never produces a `soft_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Dual-purpose sync/shutdown pin, asynchronous level |
| drv_req | input | NUM_DRIVES | Gate-drive enable requests from the modulator (bit 0 energizing, bit 1 rectifier) |
| drv_en | output | NUM_DRIVES | Gate-drive enables after shutdown gating |
| sync_pulse | output | 1 | One-cycle period-restart strobe |
| shutdown | output | 1 | Shutdown level |
| soft_start | output | 1 | One-cycle soft-start request after shutdown release |

## Verification
Two pairs of functions meet in the same cycle. Shutdown onset meets live drive requests: the bench holds both requests high through a long hold and judges that both enables drop in the very cycle the shutdown level first appears. Shutdown release meets the soft-start request: the bench drops the pin after a shutdown and requires that the level clears and the one-cycle request appears in the same cycle, exactly three edges after the fall. Neighbouring cases are run as well. These are back-to-back sync pulses with a single low sample between them, and a hold one tick short of shutdown. The bench checks that each gives its own outcome and that none leaks into the other function.

// File: rtl/sdsync_pkg.sv
// Shared types for the sync/shutdown discriminator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sdsync_pkg;

    // Operating state of the discriminator.
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } sd_state_e;

    // Counter width able to hold values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/sdsync_level_sync.sv
// Multi-flop synchronizer for a single asynchronous level.
// Assumes STAGES >= 2; the output lags the input by STAGES clock edges.
module sdsync_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $display("sdsync_level_sync: STAGES below 2 is not supported");
        end
    endgenerate

    // Shift the sampled level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/sdsync_width_timer.sv
// Measures how long a synchronized level has been high.
// The count saturates at HALT_TICKS and clears on any low sample.
// Each hit output is high for exactly one cycle per high interval,
// in the cycle its threshold is crossed. Assumes SYNC_TICKS < HALT_TICKS.
module sdsync_width_timer #(
    parameter int SYNC_TICKS = 5,
    parameter int HALT_TICKS = 1100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic sync_hit,
    output logic halt_hit
);
    import sdsync_pkg::*;

    localparam int CW = cnt_width(HALT_TICKS);
    localparam logic [CW-1:0] SYNC_AT = CW'(SYNC_TICKS - 1);
    localparam logic [CW-1:0] HALT_AT = CW'(HALT_TICKS - 1);
    localparam logic [CW-1:0] SAT_AT  = CW'(HALT_TICKS);

    logic [CW-1:0] hi_cnt;

    // Count consecutive high samples, saturating at the shutdown limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!level) begin
            hi_cnt <= '0;
        end else if (hi_cnt != SAT_AT) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // Flag the sample on which each threshold is reached.
    always_comb begin
        sync_hit = level && (hi_cnt == SYNC_AT);
        halt_hit = level && (hi_cnt == HALT_AT);
    end

endmodule

// File: rtl/sdsync_mode_fsm.sv
// Run/halt state machine with registered strobes.
// Assumes the hit inputs come from sdsync_width_timer on the same level.
module sdsync_mode_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic sync_hit,
    input  logic halt_hit,
    output logic sync_pulse,
    output logic halted,
    output logic soft_start
);
    import sdsync_pkg::*;

    sd_state_e state;

    // Track run/halt state; leave halt only when the pin drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            case (state)
                ST_RUN:  if (halt_hit) state <= ST_HALT;
                ST_HALT: if (!level)   state <= ST_RUN;
                default: state <= ST_RUN;
            endcase
        end
    end

    // Register the sync strobe and the soft-start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_pulse <= 1'b0;
            soft_start <= 1'b0;
        end else begin
            sync_pulse <= sync_hit && (state == ST_RUN);
            soft_start <= (state == ST_HALT) && !level;
        end
    end

    assign halted = (state == ST_HALT);

endmodule

// File: rtl/sdsync_discriminator.sv
// Top level: splits one pin into sync strobes and shutdown requests by
// high-interval length, and gates the gate-drive enables during shutdown.
// Assumes pin_in is a clean digital level, asynchronous to clk.
module sdsync_discriminator #(
    parameter int NUM_DRIVES  = 2,
    parameter int SYNC_STAGES = 2,
    parameter int SYNC_TICKS  = 5,
    parameter int HALT_TICKS  = 1100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pin_in,
    input  logic [NUM_DRIVES-1:0] drv_req,
    output logic [NUM_DRIVES-1:0] drv_en,
    output logic                  sync_pulse,
    output logic                  shutdown,
    output logic                  soft_start
);

    logic pin_s;
    logic sync_hit;
    logic halt_hit;

    sdsync_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (pin_s)
    );

    sdsync_width_timer #(
        .SYNC_TICKS (SYNC_TICKS),
        .HALT_TICKS (HALT_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_s),
        .sync_hit (sync_hit),
        .halt_hit (halt_hit)
    );

    sdsync_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (pin_s),
        .sync_hit   (sync_hit),
        .halt_hit   (halt_hit),
        .sync_pulse (sync_pulse),
        .halted     (shutdown),
        .soft_start (soft_start)
    );

    // Force each gate-drive enable off while shut down.
    generate
        for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_gate
            assign drv_en[g] = drv_req[g] & ~shutdown;
        end
    endgenerate

endmodule

// File: rtl/sdsync_checker.sv
// Assertion checker for sdsync_discriminator, attached by bind.
// Observes only the top-level ports.
module sdsync_checker #(
    parameter int NUM_DRIVES = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pin_in,
    input logic [NUM_DRIVES-1:0] drv_req,
    input logic [NUM_DRIVES-1:0] drv_en,
    input logic                  sync_pulse,
    input logic                  shutdown,
    input logic                  soft_start
);

    // R3: the sync strobe lasts a single cycle.
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);

    // R4: no strobe is issued while shut down.
    p_no_strobe_halted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !sync_pulse);

    // R6: shutdown rises only after the pin was high three edges earlier.
    p_halt_needs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown) |-> $past(pin_in, 3));

    // R7: enables are all off during shutdown.
    p_drive_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (drv_en == '0));

    // R7: enables follow requests in the run state.
    p_drive_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown |-> (drv_en == drv_req));

    // R8: soft-start comes with the release of shutdown.
    p_soft_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_start |-> (!shutdown && $past(shutdown)));

    // R8: soft-start lasts a single cycle.
    p_soft_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_start |=> !soft_start);

    // R8: shutdown falls only after the pin was low three edges earlier.
    p_release_needs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown) |-> !$past(pin_in, 3));

endmodule

bind sdsync_discriminator sdsync_checker #(.NUM_DRIVES(NUM_DRIVES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_in     (pin_in),
    .drv_req    (drv_req),
    .drv_en     (drv_en),
    .sync_pulse (sync_pulse),
    .shutdown   (shutdown),
    .soft_start (soft_start)
);

// File: tb/sdsync_discriminator_tb.sv
// Directed bench for sdsync_discriminator; one task per scenario.
module sdsync_discriminator_tb_top;

    localparam int ND = 2;
    localparam int ST = 5;
    localparam int HT = 1100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin_in = 1'b0;
    logic [ND-1:0] drv_req = '0;
    logic [ND-1:0] drv_en;
    logic          sync_pulse;
    logic          shutdown;
    logic          soft_start;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Observation counters, sampled at the falling edge.
    int strobe_cnt = 0;
    int last_strobe_cyc = -1;
    int ss_cnt = 0;
    int last_ss_cyc = -1;
    int sd_rise_cyc = -1;
    int sd_seen = 0;
    bit prev_sd = 1'b0;

    sdsync_discriminator #(
        .NUM_DRIVES (ND),
        .SYNC_TICKS (ST),
        .HALT_TICKS (HT)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .drv_req    (drv_req),
        .drv_en     (drv_en),
        .sync_pulse (sync_pulse),
        .shutdown   (shutdown),
        .soft_start (soft_start)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sync_pulse) begin
                strobe_cnt++;
                last_strobe_cyc = cyc;
            end
            if (soft_start) begin
                ss_cnt++;
                last_ss_cyc = cyc;
            end
            if (shutdown) sd_seen++;
            if (shutdown && !prev_sd) sd_rise_cyc = cyc;
            prev_sd = shutdown;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        strobe_cnt = 0; last_strobe_cyc = -1;
        ss_cnt = 0; last_ss_cyc = -1;
        sd_rise_cyc = -1; sd_seen = 0;
    endtask

    // Drive a high interval of w samples; returns the launch cycle.
    task automatic pulse(input int w, output int c0);
        @(negedge clk);
        c0 = cyc;
        pin_in = 1'b1;
        repeat (w) @(negedge clk);
        pin_in = 1'b0;
    endtask

    task automatic t_reset();
        drv_req = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(shutdown == 1'b0, "R1 shutdown", shutdown, 0);
        chk(sync_pulse == 1'b0 && soft_start == 1'b0, "R1 strobes",
            {sync_pulse, soft_start}, 0);
        chk(drv_en == drv_req, "R1 drv_en", drv_en, drv_req);
    endtask

    task automatic t_short_pulse();
        int c0;
        clear_obs();
        pulse(ST - 1, c0);
        repeat (10) @(negedge clk);
        pulse(1, c0);
        repeat (10) @(negedge clk);
        chk(strobe_cnt == 0, "R2 short pulses", strobe_cnt, 0);
        chk(sd_seen == 0 && ss_cnt == 0, "R2 no side effect", sd_seen + ss_cnt, 0);
    endtask

    task automatic t_valid_sync();
        int c0;
        clear_obs();
        pulse(ST, c0);
        repeat (10) @(negedge clk);
        chk(strobe_cnt == 1, "R3 strobe count", strobe_cnt, 1);
        chk(last_strobe_cyc == c0 + ST + 2, "R3 strobe cycle", last_strobe_cyc, c0 + ST + 2);
        chk(ss_cnt == 0, "R10 no soft-start after sync", ss_cnt, 0);
    endtask

    task automatic t_long_hold();
        int c0;
        clear_obs();
        pulse(300, c0);
        repeat (10) @(negedge clk);
        chk(strobe_cnt == 1, "R4 one strobe per interval", strobe_cnt, 1);
        clear_obs();
        pulse(HT - 1, c0);
        repeat (10) @(negedge clk);
        chk(sd_seen == 0, "R5 no shutdown below limit", sd_seen, 0);
        chk(ss_cnt == 0, "R10 no soft-start", ss_cnt, 0);
        chk(strobe_cnt == 1, "R4 one strobe on near-limit hold", strobe_cnt, 1);
    endtask

    task automatic t_shutdown();
        int c0, c1;
        clear_obs();
        drv_req = 2'b11;
        @(negedge clk);
        chk(drv_en == 2'b11, "R7 enables pass in run", drv_en, 3);
        c0 = cyc;
        pin_in = 1'b1;
        repeat (HT + 6) @(negedge clk);
        chk(sd_rise_cyc == c0 + HT + 2, "R6 shutdown cycle", sd_rise_cyc, c0 + HT + 2);
        chk(shutdown == 1'b1, "R6 shutdown held", shutdown, 1);
        chk(drv_en == 2'b00, "R7 enables off", drv_en, 0);
        chk(strobe_cnt == 1, "R4 single strobe before shutdown", strobe_cnt, 1);
        c1 = cyc;
        pin_in = 1'b0;
        repeat (8) @(negedge clk);
        chk(ss_cnt == 1, "R8 soft-start one cycle", ss_cnt, 1);
        chk(last_ss_cyc == c1 + 3, "R8 soft-start cycle", last_ss_cyc, c1 + 3);
        chk(shutdown == 1'b0, "R8 shutdown released", shutdown, 0);
        chk(drv_en == 2'b11, "R7 enables restored", drv_en, 3);
    endtask

    task automatic t_fast_sync();
        int c0;
        clear_obs();
        pulse(ST, c0);
        pulse(ST, c0);
        pulse(ST + 2, c0);
        repeat (10) @(negedge clk);
        chk(strobe_cnt == 3, "R9 back-to-back strobes", strobe_cnt, 3);
        chk(last_strobe_cyc == c0 + ST + 2, "R9 last strobe cycle", last_strobe_cyc, c0 + ST + 2);
        chk(ss_cnt == 0 && sd_seen == 0, "R10 no shutdown path", ss_cnt + sd_seen, 0);
    endtask

    initial begin
        t_reset();
        t_short_pulse();
        t_valid_sync();
        t_long_hold();
        t_shutdown();
        t_fast_sync();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule